// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This controller sits between a set of interrupt sources and a processor core. Each source has a pending flag and a programmable two-bit priority. Every cycle the controller picks the most urgent pending request that may interrupt the code now running. It registers that choice and presents it to the core as a request strobe, a vector number, a fast flag and a jump address. The core takes a request with a one-cycle acknowledge strobe. It leaves a service routine with a one-cycle restore strobe.

The controller keeps an active nesting threshold. Only requests at or above that threshold are eligible. On every accepted acknowledge, the threshold in force is pushed onto a small stack and a new threshold is derived from the priority just taken. A restore strobe pops the stack. Two fast slots map a chosen source to a direct jump address.

A read-only status word holds three things: the threshold and vector captured at the most recent entry, and a global disable bit that software can write.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Among pending eligible requests, the one with the highest priority is presented, ties go to the lowest source index, and `irq_vec_o` equals the source index.
- R2: A pending request is eligible only when its priority is greater than or equal to the active threshold; ineligible requests keep `irq_o` low.
- R3: Threshold codes: 00 allows priorities 0..3, 01 allows 1..3, 10 allows 2..3, 11 allows only 3. After reset the threshold is 00. Entering a routine of priority 0 gives 01, priority 1 gives 10, and priority 2 or 3 gives 11.
- R4: The status threshold (bits 14:13) and vector (bits 12:6) change only in the cycle after an accepted acknowledge. They hold through restores. A nested entry overwrites them.
- R5: When the winning source matches an enabled fast slot, `irq_fast_o` is 1 and `irq_addr_o` is that slot's address, and on entry the status vector captures the address's low 7 bits. If both slots match, slot 0 wins. Non-fast requests present address 0.
- R6: Status bit 5 is the disable bit. It resets to 0 and takes `ctl_wdata_i[5]` on a write. While it is 1, `irq_o` is low from the cycle after it is set.
- R7: Status word layout: bit 15 reads 0, bits 4:2 read 111 and bits 1:0 read 00. Writes change only bit 5.
- R8: Each accepted acknowledge pushes the active threshold onto a 4-deep stack, and a push onto a full stack drops the oldest entry. Each restore pops the stack into the active threshold, and a pop of an empty stack gives 00.
- R9: A request stays pending until it is acknowledged. `irq_o` is low in the cycle after an accepted acknowledge and is re-evaluated in the cycle after that.
- R10: An acknowledge while `irq_o` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req_i | input | N_SRC | Request pulses, one per source; a 1 sets that source pending |
| prio_we_i | input | 1 | Priority write strobe |
| prio_sel_i | input | SRC_W | Source whose priority is written |
| prio_val_i | input | 2 | New priority |
| fast_we_i | input | 1 | Fast slot write strobe |
| fast_slot_i | input | FSL_W | Slot written |
| fast_en_i | input | 1 | Slot enable |
| fast_src_i | input | SRC_W | Source mapped to the slot |
| fast_addr_i | input | ADDR_W | Jump address of the slot |
| ctl_we_i | input | 1 | Status word write strobe |
| ctl_wdata_i | input | 16 | Status write data; only bit 5 is used |
| ctl_rdata_o | output | 16 | Status word |
| irq_o | output | 1 | Request presented to the core |
| irq_vec_o | output | 7 | Vector number of the presented request |
| irq_fast_o | output | 1 | Presented request uses a fast slot |
| irq_addr_o | output | ADDR_W | Fast jump address, 0 otherwise |
| ack_i | input | 1 | Core entry strobe |
| rti_i | input | 1 | Core return strobe |

## Verification
The bench builds the block with its default parameters: 32 sources, two fast slots, 16-bit addresses and a 4-deep level stack. With a 4-deep stack, a chain of five nested entries overflows the stack in only a few dozen cycles. This shows that the oldest saved level is dropped and that an empty pop gives threshold 00. Two slots mapped to the same source show which slot wins. With 32 sources, ties and mixed priorities can be set up among widely spaced indices.

// File: rtl/nirq_pkg.sv
package nirq_pkg;

    localparam int VEC_W = 7;

    typedef logic [1:0] lvl_t;

    // Threshold in force while a routine of the given priority runs.
    function automatic lvl_t thr_after(input lvl_t prio);
        case (prio)
            2'd0:    return 2'b01;
            2'd1:    return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/nirq_arbiter.sv
module nirq_arbiter #(
    parameter int N_SRC = 32,
    localparam int SRC_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]      pend_i,
    input  logic [N_SRC-1:0][1:0] prio_i,
    input  logic [1:0]            thr_i,
    output logic                  vld_o,
    output logic [SRC_W-1:0]      idx_o,
    output logic [1:0]            prio_o
);
    logic             vld;
    logic [SRC_W-1:0] idx;
    logic [1:0]       pr;

    // Ascending scan with a strict compare keeps the lowest index on ties.
    always_comb begin
        vld = 1'b0;
        idx = '0;
        pr  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend_i[i] && (prio_i[i] >= thr_i) && (!vld || (prio_i[i] > pr))) begin
                vld = 1'b1;
                idx = SRC_W'(i);
                pr  = prio_i[i];
            end
        end
    end

    assign vld_o  = vld;
    assign idx_o  = idx;
    assign prio_o = pr;
endmodule

// File: rtl/nirq_fast_match.sv
module nirq_fast_match #(
    parameter int N_FAST = 2,
    parameter int SRC_W  = 5,
    parameter int ADDR_W = 16
) (
    input  logic [N_FAST-1:0]             en_i,
    input  logic [N_FAST-1:0][SRC_W-1:0]  src_i,
    input  logic [N_FAST-1:0][ADDR_W-1:0] addr_i,
    input  logic [SRC_W-1:0]              idx_i,
    output logic                          hit_o,
    output logic [ADDR_W-1:0]             addr_o
);
    logic [N_FAST-1:0] slot_hit;

    genvar g;
    generate
        for (g = 0; g < N_FAST; g++) begin : g_slot
            assign slot_hit[g] = en_i[g] && (src_i[g] == idx_i);
        end
    endgenerate

    // Descending scan: the lowest matching slot is written last and wins.
    always_comb begin
        hit_o  = 1'b0;
        addr_o = '0;
        for (int i = N_FAST - 1; i >= 0; i--) begin
            if (slot_hit[i]) begin
                hit_o  = 1'b1;
                addr_o = addr_i[i];
            end
        end
    end
endmodule

// File: rtl/nirq_lvl_stack.sv
module nirq_lvl_stack #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  logic [1:0] push_lvl_i,
    input  logic       pop_i,
    output logic [1:0] top_o
);
    typedef struct packed {
        logic [DEPTH-1:0][1:0] lvl;
        logic [CW-1:0]         cnt;
    } stk_t;

    stk_t d, q;

    always_comb begin
        top_o = 2'b00;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i + 1) == q.cnt) top_o = q.lvl[i];
        end
    end

    always_comb begin
        d = q;
        if (push_i) begin
            if (q.cnt == CW'(DEPTH)) begin
                // Full: slide everything down, losing the oldest level.
                for (int i = 0; i < DEPTH - 1; i++) d.lvl[i] = q.lvl[i+1];
                d.lvl[DEPTH-1] = push_lvl_i;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) == q.cnt) d.lvl[i] = push_lvl_i;
                end
                d.cnt = q.cnt + 1'b1;
            end
        end else if (pop_i && (q.cnt != '0)) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
    parameter int N_SRC     = 32,
    parameter int N_FAST    = 2,
    parameter int ADDR_W    = 16,
    parameter int STK_DEPTH = 4,
    localparam int SRC_W = $clog2(N_SRC),
    localparam int FSL_W = (N_FAST > 1) ? $clog2(N_FAST) : 1,
    localparam int VEC_W = nirq_pkg::VEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req_i,
    input  logic              prio_we_i,
    input  logic [SRC_W-1:0]  prio_sel_i,
    input  logic [1:0]        prio_val_i,
    input  logic              fast_we_i,
    input  logic [FSL_W-1:0]  fast_slot_i,
    input  logic              fast_en_i,
    input  logic [SRC_W-1:0]  fast_src_i,
    input  logic [ADDR_W-1:0] fast_addr_i,
    input  logic              ctl_we_i,
    input  logic [15:0]       ctl_wdata_i,
    output logic [15:0]       ctl_rdata_o,
    output logic              irq_o,
    output logic [VEC_W-1:0]  irq_vec_o,
    output logic              irq_fast_o,
    output logic [ADDR_W-1:0] irq_addr_o,
    input  logic              ack_i,
    input  logic              rti_i
);
    import nirq_pkg::*;

    typedef struct packed {
        logic [N_SRC-1:0]             pend;
        logic [N_SRC-1:0][1:0]        prio;
        logic [N_FAST-1:0]            f_en;
        logic [N_FAST-1:0][SRC_W-1:0] f_src;
        logic [N_FAST-1:0][ADDR_W-1:0] f_addr;
        logic [1:0]                   act_thr;
        logic [1:0]                   st_thr;
        logic [VEC_W-1:0]             st_vec;
        logic                         dis;
        logic                         irq;
        logic [SRC_W-1:0]             irq_src;
        logic [1:0]                   irq_prio;
        logic                         irq_fast;
        logic [ADDR_W-1:0]            irq_addr;
    } st_t;

    st_t d, q;

    logic              take;
    logic              win_vld;
    logic [SRC_W-1:0]  win_idx;
    logic [1:0]        win_prio;
    logic              fast_hit;
    logic [ADDR_W-1:0] fast_addr;
    logic [1:0]        stk_top;
    logic [N_SRC-1:0]  clr_mask;

    assign take     = ack_i && q.irq;
    assign clr_mask = N_SRC'(take) << q.irq_src;

    nirq_arbiter #(.N_SRC(N_SRC)) arb_i (
        .pend_i (q.pend),
        .prio_i (q.prio),
        .thr_i  (q.act_thr),
        .vld_o  (win_vld),
        .idx_o  (win_idx),
        .prio_o (win_prio)
    );

    nirq_fast_match #(.N_FAST(N_FAST), .SRC_W(SRC_W), .ADDR_W(ADDR_W)) fm_i (
        .en_i   (q.f_en),
        .src_i  (q.f_src),
        .addr_i (q.f_addr),
        .idx_i  (win_idx),
        .hit_o  (fast_hit),
        .addr_o (fast_addr)
    );

    nirq_lvl_stack #(.DEPTH(STK_DEPTH)) stk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (take),
        .push_lvl_i (q.act_thr),
        .pop_i      (rti_i && !take),
        .top_o      (stk_top)
    );

    always_comb begin
        d = q;

        // Pending flags: a fresh request outranks the clear of its own flag.
        d.pend = (q.pend & ~clr_mask) | src_req_i;

        if (prio_we_i) d.prio[prio_sel_i] = prio_val_i;

        if (fast_we_i) begin
            d.f_en[fast_slot_i]   = fast_en_i;
            d.f_src[fast_slot_i]  = fast_src_i;
            d.f_addr[fast_slot_i] = fast_addr_i;
        end

        if (ctl_we_i) d.dis = ctl_wdata_i[5];

        // Entry takes precedence over a return in the same cycle.
        if (take) begin
            d.act_thr = thr_after(q.irq_prio);
            d.st_thr  = thr_after(q.irq_prio);
            d.st_vec  = q.irq_fast ? q.irq_addr[VEC_W-1:0] : VEC_W'(q.irq_src);
        end else if (rti_i) begin
            d.act_thr = stk_top;
        end

        d.irq      = !take && !q.dis && win_vld;
        d.irq_src  = win_idx;
        d.irq_prio = win_prio;
        d.irq_fast = fast_hit;
        d.irq_addr = fast_hit ? fast_addr : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctl_rdata_o = {1'b0, q.st_thr, q.st_vec, q.dis, 3'b111, 2'b00};
    assign irq_o       = q.irq;
    assign irq_vec_o   = VEC_W'(q.irq_src);
    assign irq_fast_o  = q.irq_fast;
    assign irq_addr_o  = q.irq_addr;
endmodule

// File: rtl/nirq_chk.sv
module nirq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_i,
    input logic              irq_o,
    input logic              irq_fast_o,
    input logic [ADDR_W-1:0] irq_addr_o,
    input logic [15:0]       ctl_rdata_o
);
    // R9: no request in the cycle after an accepted entry
    p_drop_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> !irq_o);

    // R4: snapshot fields move only after an accepted entry
    p_hold_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_i && irq_o) |=> $stable(ctl_rdata_o[14:6]));

    // R3: an entry never leaves the captured threshold at 00
    p_entry_thr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> (ctl_rdata_o[14:13] != 2'b00));

    // R6: a set disable bit silences the request in the next cycle
    p_disable_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata_o[5] |=> !irq_o);

    // R5: a normal request carries no jump address
    p_plain_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_fast_o) |-> (irq_addr_o == '0));
endmodule

bind nest_irq_ctrl nirq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .irq_o       (irq_o),
    .irq_fast_o  (irq_fast_o),
    .irq_addr_o  (irq_addr_o),
    .ctl_rdata_o (ctl_rdata_o)
);

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req_i = '0;
    logic        prio_we_i = 1'b0;
    logic [4:0]  prio_sel_i = '0;
    logic [1:0]  prio_val_i = '0;
    logic        fast_we_i = 1'b0;
    logic [0:0]  fast_slot_i = '0;
    logic        fast_en_i = 1'b0;
    logic [4:0]  fast_src_i = '0;
    logic [15:0] fast_addr_i = '0;
    logic        ctl_we_i = 1'b0;
    logic [15:0] ctl_wdata_i = '0;
    logic [15:0] ctl_rdata_o;
    logic        irq_o;
    logic [6:0]  irq_vec_o;
    logic        irq_fast_o;
    logic [15:0] irq_addr_o;
    logic        ack_i = 1'b0;
    logic        rti_i = 1'b0;

    int nchk = 0;
    int nfail = 0;

    typedef struct {
        logic [6:0]  vec;
        logic        fast;
        logic [15:0] addr;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    nest_irq_ctrl dut_i (.*);

    // Monitor: compare each accepted entry against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && ack_i && irq_o) begin
            nchk++;
            if (exp_q.size() == 0) begin
                nfail++;
                $display("FAIL R1: unexpected entry vec=%0d", irq_vec_o);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (irq_vec_o != e.vec || irq_fast_o != e.fast || irq_addr_o != e.addr) begin
                    nfail++;
                    $display("FAIL R1/R5: vec=%0d fast=%0b addr=%h expected vec=%0d fast=%0b addr=%h",
                             irq_vec_o, irq_fast_o, irq_addr_o, e.vec, e.fast, e.addr);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] stat(input logic [1:0] thr, input logic [6:0] vec, input logic dis);
        return {1'b0, thr, vec, dis, 5'b11100};
    endfunction

    task automatic set_prio(input int src, input logic [1:0] p);
        prio_we_i = 1'b1; prio_sel_i = 5'(src); prio_val_i = p;
        tick();
        prio_we_i = 1'b0;
    endtask

    task automatic set_fast(input int slot, input int src, input logic [15:0] a);
        fast_we_i = 1'b1; fast_slot_i = 1'(slot); fast_en_i = 1'b1;
        fast_src_i = 5'(src); fast_addr_i = a;
        tick();
        fast_we_i = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] m);
        src_req_i = m;
        tick();
        src_req_i = '0;
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        ctl_we_i = 1'b1; ctl_wdata_i = v;
        tick();
        ctl_we_i = 1'b0;
    endtask

    task automatic rti();
        rti_i = 1'b1;
        tick();
        rti_i = 1'b0;
    endtask

    task automatic quiet(input string tag);
        tick(); tick(); tick();
        chk(tag, 16'(irq_o), 16'h0);
    endtask

    // Driver: wait for a request, queue what it must be, then accept it.
    task automatic take(input int vec, input logic f, input logic [15:0] a);
        exp_t e;
        for (int i = 0; i < 20 && !irq_o; i++) tick();
        e.vec = 7'(vec); e.fast = f; e.addr = a;
        exp_q.push_back(e);
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0;
        chk("R9 irq low after entry", 16'(irq_o), 16'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R3/R7 reset status", ctl_rdata_o, stat(2'b00, 7'd0, 1'b0));
        chk("R9 reset irq", 16'(irq_o), 16'h0);

        // R1: priority then lowest index
        set_prio(3, 2'd2); set_prio(5, 2'd1); set_prio(9, 2'd2);
        pulse(32'h0000_0228);
        take(3, 1'b0, 16'h0);
        chk("R3 entry prio2", ctl_rdata_o, stat(2'b11, 7'd3, 1'b0));
        quiet("R2 prio2 blocked at 11");
        rti();
        chk("R4 hold on restore", ctl_rdata_o, stat(2'b11, 7'd3, 1'b0));
        take(9, 1'b0, 16'h0);
        rti();
        take(5, 1'b0, 16'h0);
        chk("R3 entry prio1", ctl_rdata_o, stat(2'b10, 7'd5, 1'b0));

        // Nesting over a priority-1 routine
        set_prio(20, 2'd3); set_prio(21, 2'd1);
        pulse(32'h0030_0000);
        take(20, 1'b0, 16'h0);
        chk("R4 nested overwrite", ctl_rdata_o, stat(2'b11, 7'd20, 1'b0));
        quiet("R2 prio1 blocked at 11");
        rti();
        quiet("R8 restored 10 blocks prio1");
        rti();
        take(21, 1'b0, 16'h0);
        chk("R3 entry src21", ctl_rdata_o, stat(2'b10, 7'd21, 1'b0));
        rti();

        // R5: fast slots, slot 0 wins
        set_fast(1, 7, 16'hBEEF);
        set_fast(0, 7, 16'h1234);
        pulse(32'h0000_0080);
        take(7, 1'b1, 16'h1234);
        chk("R5 fast vector capture", ctl_rdata_o, stat(2'b01, 7'h34, 1'b0));
        rti();

        // R6/R7: disable and masked write
        wr_ctl(16'hFFFF);
        chk("R7 write only bit5", ctl_rdata_o, stat(2'b01, 7'h34, 1'b1));
        pulse(32'h0000_0002);
        quiet("R6 disabled irq");
        ack_i = 1'b1; tick(); ack_i = 1'b0;
        tick();
        chk("R10 ack ignored", ctl_rdata_o, stat(2'b01, 7'h34, 1'b1));
        wr_ctl(16'h0000);
        take(1, 1'b0, 16'h0);
        chk("R6 re-enabled entry", ctl_rdata_o, stat(2'b01, 7'd1, 1'b0));
        rti();

        // R8: overflow drops oldest, empty pop gives 00
        set_prio(10, 2'd0); set_prio(11, 2'd1); set_prio(12, 2'd2);
        set_prio(13, 2'd3); set_prio(14, 2'd3);
        set_prio(15, 2'd0); set_prio(16, 2'd1);
        for (int s = 10; s <= 14; s++) begin
            pulse(32'h1 << s);
            take(s, 1'b0, 16'h0);
        end
        chk("R8 chain status", ctl_rdata_o, stat(2'b11, 7'd14, 1'b0));
        pulse(32'h0001_8000);
        quiet("R8 depth5 blocked");
        rti(); quiet("R8 pop1 blocked");
        rti(); quiet("R8 pop2 blocked");
        rti(); quiet("R8 pop3 at 10 blocked");
        rti();
        take(16, 1'b0, 16'h0);
        chk("R8 after pop4", ctl_rdata_o, stat(2'b10, 7'd16, 1'b0));
        rti();
        quiet("R8 restored 01 blocks prio0");
        rti();
        take(15, 1'b0, 16'h0);
        chk("R8 underflow to 00", ctl_rdata_o, stat(2'b01, 7'd15, 1'b0));
        rti();
        quiet("R9 nothing pending");

        tick();
        chk("R1 scoreboard drained", 16'(exp_q.size()), 16'h0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule